// File: doc/BRIEF.md
# Command Wait and Branch Sequencer

This block sits in a DMA channel's command engine and decides what happens to the command pointer once a command has been fetched. Each command carries a two-bit wait mode and a two-bit branch mode. Both modes are judged against one condition bit, which is derived from the channel's status word through a select mask and a select value. The block first decides whether the channel must hold on the current command. If it does not hold, the block either advances the pointer to the next 16-byte command or loads the command's branch target.

A stop opcode ends the channel's activity and leaves the pointer where it is. A start pulse loads a new pointer and activates the channel. While the channel is inactive, presented commands are ignored. The stall and retire outputs are combinational for the current command, and the pointer update lands on the next clock edge.

Top module: `cmd_seq`

## Requirements
- R1: While rstN is low, and on the first cycle after reset, cmdPtr is 0, chanActive is 0, and stall and retire are 0.
- R2: A start pulse loads startAddr into cmdPtr and sets chanActive on the next edge. Start has priority over any command presented in the same cycle; that command neither stalls nor retires.
- R3: The condition bit is true exactly when (statusBits AND selMask) equals (selValue AND selMask). With selMask zero, it is always true.
- R4: The waitMode encoding is 2'b00 never, 2'b01 if the condition is true, 2'b10 if the condition is false, and 2'b11 always. For an active non-stop command, stall is driven in the same cycle and retire is low while stalled.
- R5: While stall is high, cmdPtr holds. The condition is re-evaluated every cycle, so a status change releases the stall and lets the command retire.
- R6: The branchMode encoding is the same as the waitMode encoding. When a retiring command's branch is not taken, cmdPtr becomes cmdPtr+16 (modulo 2^32).
- R7: When a retiring command's branch is taken, cmdPtr becomes branchAddr.
- R8: A command with cmdOp 4'h7 (stop) clears chanActive and leaves cmdPtr unchanged, never stalls or retires whatever its wait mode is, and keeps later commands from having any effect.
- R9: While chanActive is 0 and start is low, cmdValid has no effect: cmdPtr is unchanged and stall and retire stay 0.
- R10: Every opcode other than 4'h7 (the four transfer kinds 0 to 3, and word load/store 5 and 6) follows the same wait and branch rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load startAddr and activate the channel |
| startAddr | input | 32 | Initial command pointer |
| cmdValid | input | 1 | A fetched command is presented |
| cmdOp | input | 4 | Command opcode (4'h7 = stop) |
| waitMode | input | 2 | Wait mode of the command |
| branchMode | input | 2 | Branch mode of the command |
| statusBits | input | 16 | Channel status word used for the condition |
| selMask | input | 16 | Condition select mask |
| selValue | input | 16 | Condition select value |
| branchAddr | input | 32 | Branch target of the command |
| cmdPtr | output | 32 | Current command pointer |
| chanActive | output | 1 | Channel is active |
| stall | output | 1 | Current command must wait |
| retire | output | 1 | Current command completes this cycle |

## Verification
A vector table pairs each wait mode and each branch mode with condition inputs that make the condition true and that make it false. The table includes a partial mask where the unmasked bits disagree, and one where a single masked nibble disagrees, which separates a masked compare from a plain equality. The table is walked with a tracked pointer, so advance, jump and hold can each be told apart from the others. Directed cases cover:
- a stall released by a status change;
- a stop whose wait mode is "always";
- commands presented to an idle channel;
- start colliding with a command;
- pointer wraparound at the top of the address space.

// File: rtl/cmd_seq_pkg.sv
`timescale 1ns/1ps
package cmd_seq_pkg;
  localparam int CMD_BYTES = 16;

  typedef enum logic [1:0] {
    MODE_NEVER  = 2'b00,
    MODE_IFSET  = 2'b01,
    MODE_IFCLR  = 2'b10,
    MODE_ALWAYS = 2'b11
  } condMode_e;

  typedef struct packed {
    logic load;     // take startAddr, go active
    logic advance;  // step to next command
    logic jump;     // take branch target
    logic halt;     // stop: drop active
  } seqStrobe_t;

  function automatic logic modeHit(input logic [1:0] mode, input logic cond);
    case (condMode_e'(mode))
      MODE_NEVER:  modeHit = 1'b0;
      MODE_IFSET:  modeHit = cond;
      MODE_IFCLR:  modeHit = !cond;
      default:     modeHit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/cmd_seq_ctrl.sv
`timescale 1ns/1ps
module cmd_seq_ctrl
  import cmd_seq_pkg::*;
#(
  parameter int STAT_W  = 16,
  parameter int OP_W    = 4,
  parameter int STOP_OP = 7
) (
  input  logic              start,
  input  logic              active,
  input  logic              cmdValid,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [1:0]        waitMode,
  input  logic [1:0]        branchMode,
  input  logic [STAT_W-1:0] statusBits,
  input  logic [STAT_W-1:0] selMask,
  input  logic [STAT_W-1:0] selValue,
  output seqStrobe_t        strobe,
  output logic              stall,
  output logic              retire
);
  localparam logic [OP_W-1:0] STOP_CODE = OP_W'(STOP_OP);

  logic [STAT_W-1:0] bitOk;
  logic condBit;
  logic live;
  logic isStop;
  logic waitReq;
  logic takeBranch;

  // per-bit select match: unselected bits always agree
  for (genvar i = 0; i < STAT_W; i++) begin : g_match
    assign bitOk[i] = !selMask[i] || (statusBits[i] == selValue[i]);
  end

  assign condBit    = &bitOk;
  assign live       = active && cmdValid && !start;
  assign isStop     = (cmdOp == STOP_CODE);
  assign waitReq    = modeHit(waitMode, condBit);
  assign takeBranch = modeHit(branchMode, condBit);

  always_comb begin
    strobe         = '0;
    strobe.load    = start;
    stall          = 1'b0;
    retire         = 1'b0;
    if (live) begin
      if (isStop) begin
        strobe.halt = 1'b1;
      end else if (waitReq) begin
        stall = 1'b1;
      end else begin
        retire         = 1'b1;
        strobe.jump    = takeBranch;
        strobe.advance = !takeBranch;
      end
    end
  end
endmodule

// File: rtl/cmd_seq_datapath.sv
`timescale 1ns/1ps
module cmd_seq_datapath
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] branchAddr,
  output logic [ADDR_W-1:0] cmdPtr,
  output logic              chanActive
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(CMD_BYTES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPtr     <= '0;
      chanActive <= 1'b0;
    end else begin
      if (strobe.load) begin
        cmdPtr     <= startAddr;
        chanActive <= 1'b1;
      end else begin
        if (strobe.jump)    cmdPtr <= branchAddr;
        if (strobe.advance) cmdPtr <= cmdPtr + STEP;
        if (strobe.halt)    chanActive <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_seq.sv
`timescale 1ns/1ps
module cmd_seq
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STAT_W  = 16,
  parameter int OP_W    = 4,
  parameter int STOP_OP = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              cmdValid,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [1:0]        waitMode,
  input  logic [1:0]        branchMode,
  input  logic [STAT_W-1:0] statusBits,
  input  logic [STAT_W-1:0] selMask,
  input  logic [STAT_W-1:0] selValue,
  input  logic [ADDR_W-1:0] branchAddr,
  output logic [ADDR_W-1:0] cmdPtr,
  output logic              chanActive,
  output logic              stall,
  output logic              retire
);
  seqStrobe_t strobe;

  cmd_seq_ctrl #(.STAT_W(STAT_W), .OP_W(OP_W), .STOP_OP(STOP_OP)) u_ctrl (
    .start(start), .active(chanActive), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .waitMode(waitMode), .branchMode(branchMode), .statusBits(statusBits),
    .selMask(selMask), .selValue(selValue), .strobe(strobe),
    .stall(stall), .retire(retire)
  );

  cmd_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .branchAddr(branchAddr), .cmdPtr(cmdPtr), .chanActive(chanActive)
  );
endmodule

// File: rtl/cmd_seq_checker.sv
`timescale 1ns/1ps
module cmd_seq_checker #(
  parameter int ADDR_W  = 32,
  parameter int OP_W    = 4,
  parameter int STOP_OP = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] startAddr,
  input logic              cmdValid,
  input logic [OP_W-1:0]   cmdOp,
  input logic [1:0]        branchMode,
  input logic [ADDR_W-1:0] cmdPtr,
  input logic              chanActive,
  input logic              stall,
  input logic              retire
);
  // R2
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rstN)
    start |=> chanActive && cmdPtr == $past(startAddr));

  // R4
  a_r4_stall_not_retire: assert property (@(posedge clk) disable iff (!rstN)
    !(stall && retire));

  // R5
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(cmdPtr));

  // R6
  a_r6_never_branch_steps: assert property (@(posedge clk) disable iff (!rstN)
    (retire && branchMode == 2'b00) |=> cmdPtr == $past(cmdPtr) + ADDR_W'(16));

  // R8
  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive && cmdValid && !start && cmdOp == OP_W'(STOP_OP))
      |=> !chanActive && $stable(cmdPtr));

  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!chanActive && !start) |=> $stable(cmdPtr) && !chanActive);

  // R9
  a_r9_idle_no_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive |-> !stall && !retire);
endmodule

bind cmd_seq cmd_seq_checker #(.ADDR_W(ADDR_W), .OP_W(OP_W), .STOP_OP(STOP_OP)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .branchMode(branchMode),
  .cmdPtr(cmdPtr), .chanActive(chanActive), .stall(stall), .retire(retire)
);

// File: tb/cmd_seq_bench.sv
`timescale 1ns/1ps
module cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] startAddr = '0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = '0;
  logic [1:0]  waitMode = '0;
  logic [1:0]  branchMode = '0;
  logic [15:0] statusBits = '0;
  logic [15:0] selMask = '0;
  logic [15:0] selValue = '0;
  logic [31:0] branchAddr = '0;
  logic [31:0] cmdPtr;
  logic        chanActive, stall, retire;

  int checks = 0;
  int errors = 0;
  logic [31:0] expPtr;

  always #5 clk = ~clk;

  cmd_seq u_cmd_seq (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .waitMode(waitMode),
    .branchMode(branchMode), .statusBits(statusBits), .selMask(selMask),
    .selValue(selValue), .branchAddr(branchAddr), .cmdPtr(cmdPtr),
    .chanActive(chanActive), .stall(stall), .retire(retire)
  );

  // {wait, branch, status, mask, value, expStall, expTaken}
  localparam logic [53:0] VEC [13] = '{
    {2'd0, 2'd0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0},
    {2'd0, 2'd3, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1},
    {2'd0, 2'd1, 16'h0010, 16'h0010, 16'h0010, 1'b0, 1'b1},
    {2'd0, 2'd1, 16'h0000, 16'h0010, 16'h0010, 1'b0, 1'b0},
    {2'd0, 2'd2, 16'h0000, 16'h0010, 16'h0010, 1'b0, 1'b1},
    {2'd0, 2'd2, 16'h0010, 16'h0010, 16'h0010, 1'b0, 1'b0},
    {2'd3, 2'd3, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {2'd1, 2'd0, 16'h00F0, 16'h00F0, 16'h00F0, 1'b1, 1'b0},
    {2'd1, 2'd3, 16'h0000, 16'h00F0, 16'h00F0, 1'b0, 1'b1},
    {2'd2, 2'd0, 16'h0000, 16'h00F0, 16'h00F0, 1'b1, 1'b0},
    {2'd2, 2'd1, 16'h00F0, 16'h00F0, 16'h00F0, 1'b0, 1'b1},
    {2'd0, 2'd1, 16'hABCD, 16'hFF00, 16'hAB12, 1'b0, 1'b1},
    {2'd0, 2'd1, 16'hABCD, 16'hFF0F, 16'hAB12, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic setCmd(input logic [3:0] op, input logic [1:0] w, input logic [1:0] b,
                        input logic [15:0] st, input logic [15:0] m, input logic [15:0] v,
                        input logic [31:0] ba);
    cmdValid = 1'b1; cmdOp = op; waitMode = w; branchMode = b;
    statusBits = st; selMask = m; selValue = v; branchAddr = ba;
  endtask

  task automatic doStart(input logic [31:0] a);
    @(negedge clk);
    cmdValid = 1'b0; start = 1'b1; startAddr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(100000 * 10);
    errors++;
    $display("FAIL all requirements: watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 ptr in reset", cmdPtr, 32'h0);
    chk("R1 active in reset", {31'b0, chanActive}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ptr after reset", cmdPtr, 32'h0);
    chk("R1 stall/retire after reset", {30'b0, stall, retire}, 32'h0);

    // R9: commands are ignored while inactive
    setCmd(4'h0, 2'd0, 2'd3, 16'h0, 16'h0, 16'h0, 32'h5000);
    #1;
    chk("R9 idle stall/retire", {30'b0, stall, retire}, 32'h0);
    @(posedge clk); #1;
    chk("R9 idle ptr unchanged", cmdPtr, 32'h0);
    chk("R9 idle stays inactive", {31'b0, chanActive}, 32'h0);

    // R2 start loads pointer
    doStart(32'h0000_0200);
    chk("R2 start ptr", cmdPtr, 32'h0000_0200);
    chk("R2 start active", {31'b0, chanActive}, 32'h1);
    expPtr = 32'h0000_0200;

    // R3 R4 R6 R7 R10: vector table walk
    for (int i = 0; i < 13; i++) begin
      logic [53:0] v;
      logic [31:0] ba;
      v  = VEC[i];
      ba = 32'h0000_1000 + 32'(i) * 32'h100;
      @(negedge clk);
      setCmd(4'(i % 7), v[53:52], v[51:50], v[49:34], v[33:18], v[17:2], ba);
      if (cmdOp == 4'h4) cmdOp = 4'h6;
      #1;
      chk($sformatf("R4 R3 vec%0d stall", i), {31'b0, stall}, {31'b0, v[1]});
      chk($sformatf("R4 R10 vec%0d retire", i), {31'b0, retire}, {31'b0, !v[1]});
      @(posedge clk); #1;
      if (!v[1]) expPtr = v[0] ? ba : expPtr + 32'h10;
      chk($sformatf("R6 R7 R5 vec%0d ptr", i), cmdPtr, expPtr);
    end

    // R5: stall held, then released by a status change
    @(negedge clk);
    setCmd(4'h2, 2'd1, 2'd0, 16'h0001, 16'h0001, 16'h0001, 32'h9000);
    repeat (2) begin
      #1;
      chk("R5 stall while cond set", {31'b0, stall}, 32'h1);
      @(posedge clk); #1;
      chk("R5 ptr holds while stalled", cmdPtr, expPtr);
      @(negedge clk);
    end
    statusBits = 16'h0000;
    #1;
    chk("R5 stall released", {30'b0, stall, retire}, 32'h1);
    @(posedge clk); #1;
    expPtr = expPtr + 32'h10;
    chk("R5 advance after release", cmdPtr, expPtr);

    // R8: stop with wait=always
    @(negedge clk);
    setCmd(4'h7, 2'd3, 2'd3, 16'h0, 16'h0, 16'h0, 32'h7000);
    #1;
    chk("R8 stop no stall/retire", {30'b0, stall, retire}, 32'h0);
    @(posedge clk); #1;
    chk("R8 stop ptr unchanged", cmdPtr, expPtr);
    chk("R8 stop inactive", {31'b0, chanActive}, 32'h0);
    @(negedge clk);
    setCmd(4'h0, 2'd0, 2'd3, 16'h0, 16'h0, 16'h0, 32'h7700);
    @(posedge clk); #1;
    chk("R8 R9 after stop ignored", cmdPtr, expPtr);

    // R2: start wins over a same-cycle command
    @(negedge clk);
    setCmd(4'h1, 2'd0, 2'd3, 16'h0, 16'h0, 16'h0, 32'h8800);
    start = 1'b1; startAddr = 32'h0000_0400;
    #1;
    chk("R2 start blocks retire", {30'b0, stall, retire}, 32'h0);
    @(posedge clk); #1;
    chk("R2 start priority ptr", cmdPtr, 32'h0000_0400);
    @(negedge clk);
    start = 1'b0; cmdValid = 1'b0;

    // R6: wraparound
    doStart(32'hFFFF_FFF0);
    setCmd(4'h3, 2'd0, 2'd0, 16'h0, 16'h0, 16'h0, 32'h1234_0000);
    @(posedge clk); #1;
    chk("R6 wrap to zero", cmdPtr, 32'h0);
    @(negedge clk);
    cmdValid = 1'b0;

    finishRun();
  end
endmodule